// File: doc/BRIEF.md
# Tiled Color/Depth Write-Back Cache

This block sits beside a pixel pipeline and keeps a few 8x8 screen tiles of color and depth in on-chip storage. Fragments (x, y, depth, color) arrive on a valid/ready handshake. The block finds the tile that holds each fragment. It runs a strict less-than depth test against the cached depth. It updates color and depth only when the fragment is visible. A per-pixel dirty mask records every pixel changed since the tile was loaded.

When a fragment lands in a tile that is not cached, the block picks a victim entry. If the victim holds changed pixels, those are written to memory first. The new tile is then loaded one 256-bit row at a time, with color and depth alternating. During all of this the fragment input is stalled. Writes to memory are deferred until an entry is reused or a flush is requested, so later primitives can keep drawing into the same cached tile. A write-back sends only the changed pixels, using per-lane enables, and skips clean rows altogether.

Top module: `tc_tile_cache`

## Requirements
- R1: A fragment at (x, y) belongs to tile `{y[Y_W-1:3], x[X_W-1:3]}`. In memory it lives in row `y[2:0]` of that tile, in lane `x[2:0]`, and lane L occupies data bits `32*L+31 : 32*L`.
- R2: A miss stalls the fragment with `frag_ready` low. The tile is then loaded with 16 reads in the order row 0 color, row 0 depth, row 1 color, and so on up to row 7 depth. `mem_depth` is 0 for the color region and 1 for the depth region, and every read carries `mem_lane_en` = 8'hFF. Only after the loads is the fragment accepted.
- R3: A fragment is visible only when its depth is strictly less than the cached depth at its pixel. An equal or larger depth leaves both color and depth unchanged.
- R4: A write-back issues a write only for rows that contain a changed pixel. Each write has `mem_lane_en` equal to that row's dirty bits, so untouched pixels in memory keep their old values.
- R5: Fragments that hit a cached tile cause no memory traffic.
- R6: Replacement uses an invalid entry first, and otherwise the least recently used entry. Accepting a fragment makes its entry the most recently used.
- R7: If the victim has changed pixels, all of its writes complete before the first read of the new tile.
- R8: A one-cycle pulse on `flush_req` writes back every changed pixel of every entry and invalidates all entries, so the next fragment to any tile misses. Completion is marked by `flush_done` high for exactly one cycle.
- R9: While reset is asserted, `mem_req` and `flush_done` are low. After reset no entry is valid and no memory access happens until a fragment or a flush arrives.
- R10: Once `mem_req` is raised, it and the address fields (`mem_we`, `mem_depth`, `mem_row`, `mem_tile`) hold steady until the cycle in which `mem_ack` is high.
- R11: The dirty mask is cleared after each write-back and each load. A flush with no changed pixels therefore issues no writes and still pulses `flush_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Fragment accepted this cycle when valid is also high |
| frag_x | input | X_W | Screen x |
| frag_y | input | Y_W | Screen y |
| frag_z | input | 32 | Fragment depth |
| frag_color | input | 32 | Fragment color |
| flush_req | input | 1 | Request to write back and invalidate everything |
| flush_done | output | 1 | One-cycle completion pulse for a flush |
| mem_req | output | 1 | Row access request |
| mem_ack | input | 1 | Access completes this cycle; read data valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_depth | output | 1 | Region select: 0 color, 1 depth |
| mem_tile | output | X_W+Y_W-6 | Tile index of the access |
| mem_row | output | 3 | Row within the tile |
| mem_lane_en | output | 8 | Per-pixel write enable |
| mem_wdata | output | 256 | Write row |
| mem_rdata | input | 256 | Read row |

## Verification
A corrupted dirty mask or depth value stays hidden until the tile is written back. It then shows up as a wrong lane enable, a spurious row write or a wrong value landing in memory, so the bench forces flushes and evictions right after each scenario. A wrong tag or wrong replacement state shows at once as unexpected reads on a fragment that should hit, or as a write-back of the wrong tile. The order and count of row accesses on a miss are compared access by access against the expected sequence.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int PIX_W    = 32;
  localparam int OFF_W    = 3;
  localparam int LANES    = 1 << OFF_W;
  localparam int ROW_W    = PIX_W * LANES;
  localparam int TILE_PIX = LANES * LANES;
  localparam int PIX_IDX_W = 2 * OFF_W;
  localparam int STEP_W   = OFF_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_DONE
  } tc_state_e;
endpackage

// File: rtl/tc_tag_lookup.sv
module tc_tag_lookup #(
  parameter int ENTRIES = 2,
  parameter int IDX_W   = 1,
  parameter int TAG_W   = 16
) (
  input  logic [TAG_W-1:0]   tag_i   [ENTRIES],
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   rank_i  [ENTRIES],
  input  logic [TAG_W-1:0]   query_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [IDX_W-1:0]   victim_o
);
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid_i[e] && (tag_i[e] == query_i);
  end

  assign hit_o = |match;

  always_comb begin
    logic             found_inv;
    logic [IDX_W-1:0] inv_idx;
    logic [IDX_W-1:0] old_idx;
    hit_idx_o = '0;
    found_inv = 1'b0;
    inv_idx   = '0;
    old_idx   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) hit_idx_o = IDX_W'(e);
      if (rank_i[e] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(e);
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_i[e]) begin
        found_inv = 1'b1;
        inv_idx   = IDX_W'(e);
      end
    end
    victim_o = found_inv ? inv_idx : old_idx;
  end
endmodule

// File: rtl/tc_entry_store.sv
module tc_entry_store
  import tc_pkg::*;
#(
  parameter int ENTRIES = 2,
  parameter int IDX_W   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 px_we,
  input  logic [IDX_W-1:0]     px_ent,
  input  logic [PIX_IDX_W-1:0] px_idx,
  input  logic [PIX_W-1:0]     px_color,
  input  logic [PIX_W-1:0]     px_depth,
  input  logic                 row_we,
  input  logic [IDX_W-1:0]     row_ent,
  input  logic [OFF_W-1:0]     row_sel,
  input  logic                 row_dep,
  input  logic [ROW_W-1:0]     row_data,
  input  logic                 dirty_clr,
  input  logic [IDX_W-1:0]     dirty_ent,
  input  logic [IDX_W-1:0]     rd_ent,
  input  logic [PIX_IDX_W-1:0] rd_idx,
  output logic [PIX_W-1:0]     rd_depth,
  input  logic [IDX_W-1:0]     rr_ent,
  input  logic [OFF_W-1:0]     rr_row,
  input  logic                 rr_dep,
  output logic [ROW_W-1:0]     rr_data,
  output logic [LANES-1:0]     rr_dirty,
  output logic [ENTRIES-1:0]   dirty_any
);
  logic [PIX_W-1:0]    col_q   [ENTRIES][TILE_PIX];
  logic [PIX_W-1:0]    dep_q   [ENTRIES][TILE_PIX];
  logic [TILE_PIX-1:0] dirty_q [ENTRIES];

  // pixel arrays: no reset, validity is tracked by the controller
  always_ff @(posedge clk) begin
    if (px_we) begin
      col_q[px_ent][px_idx] <= px_color;
      dep_q[px_ent][px_idx] <= px_depth;
    end
    if (row_we) begin
      for (int l = 0; l < LANES; l++) begin
        if (row_dep) dep_q[row_ent][{row_sel, OFF_W'(l)}] <= row_data[PIX_W*l +: PIX_W];
        else         col_q[row_ent][{row_sel, OFF_W'(l)}] <= row_data[PIX_W*l +: PIX_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) dirty_q[e] <= '0;
    end else begin
      if (dirty_clr) dirty_q[dirty_ent] <= '0;
      if (px_we)     dirty_q[px_ent][px_idx] <= 1'b1;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_any
    assign dirty_any[e] = |dirty_q[e];
  end

  assign rd_depth = dep_q[rd_ent][rd_idx];
  assign rr_dirty = dirty_q[rr_ent][LANES*rr_row +: LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rr_data[PIX_W*l +: PIX_W] = rr_dep ? dep_q[rr_ent][{rr_row, OFF_W'(l)}]
                                         : col_q[rr_ent][{rr_row, OFF_W'(l)}];
    end
  end
endmodule

// File: rtl/tc_tile_cache.sv
module tc_tile_cache
  import tc_pkg::*;
#(
  parameter int X_W     = 11,
  parameter int Y_W     = 11,
  parameter int ENTRIES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frag_valid,
  output logic                 frag_ready,
  input  logic [X_W-1:0]       frag_x,
  input  logic [Y_W-1:0]       frag_y,
  input  logic [31:0]          frag_z,
  input  logic [31:0]          frag_color,
  input  logic                 flush_req,
  output logic                 flush_done,
  output logic                 mem_req,
  input  logic                 mem_ack,
  output logic                 mem_we,
  output logic                 mem_depth,
  output logic [X_W+Y_W-7:0]   mem_tile,
  output logic [2:0]           mem_row,
  output logic [7:0]           mem_lane_en,
  output logic [255:0]         mem_wdata,
  input  logic [255:0]         mem_rdata
);
  localparam int TAG_W = X_W + Y_W - 2 * OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = '1;

  tc_state_e state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [IDX_W-1:0]  wb_ent_q, wb_ent_n;
  logic [IDX_W-1:0]  fill_ent_q, fill_ent_n;
  logic [TAG_W-1:0]  fill_tile_q, fill_tile_n;
  logic              flushing_q, flushing_n;
  logic              flush_pend_q, flush_pend_n;
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_n  [ENTRIES];
  logic [IDX_W-1:0]  rank_q [ENTRIES];
  logic [IDX_W-1:0]  rank_n [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_n;

  logic [TAG_W-1:0]     frag_tile;
  logic [PIX_IDX_W-1:0] frag_pix;
  logic                 hit;
  logic [IDX_W-1:0]     hit_idx, victim;
  logic [PIX_W-1:0]     cur_depth;
  logic [ROW_W-1:0]     row_rd;
  logic [LANES-1:0]     row_dirty;
  logic [ENTRIES-1:0]   dirty_any;
  logic                 accept, visible, step_adv, step_last;
  logic                 dirty_clr;
  logic [IDX_W-1:0]     dirty_ent;

  assign frag_tile = {frag_y[Y_W-1:OFF_W], frag_x[X_W-1:OFF_W]};
  assign frag_pix  = {frag_y[OFF_W-1:0], frag_x[OFF_W-1:0]};

  tc_tag_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lookup (
    .tag_i     (tag_q),
    .valid_i   (valid_q),
    .rank_i    (rank_q),
    .query_i   (frag_tile),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .victim_o  (victim)
  );

  assign frag_ready = (state_q == ST_IDLE) && !flush_pend_q && hit;
  assign accept     = frag_valid && frag_ready;
  assign visible    = frag_z < cur_depth;
  assign step_last  = (step_q == LAST_STEP);

  assign mem_we      = (state_q == ST_WB);
  assign mem_req     = ((state_q == ST_WB) && (row_dirty != '0)) || (state_q == ST_FILL);
  assign mem_row     = step_q[STEP_W-1:1];
  assign mem_depth   = step_q[0];
  assign mem_tile    = (state_q == ST_WB) ? tag_q[wb_ent_q] : fill_tile_q;
  assign mem_lane_en = (state_q == ST_WB) ? row_dirty : '1;
  assign mem_wdata   = row_rd;
  assign flush_done  = (state_q == ST_DONE);

  assign step_adv = ((state_q == ST_WB) && ((row_dirty == '0) || mem_ack)) ||
                    ((state_q == ST_FILL) && mem_ack);
  assign dirty_clr = step_adv && step_last;
  assign dirty_ent = (state_q == ST_WB) ? wb_ent_q : fill_ent_q;

  tc_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .px_we     (accept && visible),
    .px_ent    (hit_idx),
    .px_idx    (frag_pix),
    .px_color  (frag_color),
    .px_depth  (frag_z),
    .row_we    ((state_q == ST_FILL) && mem_ack),
    .row_ent   (fill_ent_q),
    .row_sel   (mem_row),
    .row_dep   (mem_depth),
    .row_data  (mem_rdata),
    .dirty_clr (dirty_clr),
    .dirty_ent (dirty_ent),
    .rd_ent    (hit_idx),
    .rd_idx    (frag_pix),
    .rd_depth  (cur_depth),
    .rr_ent    (wb_ent_q),
    .rr_row    (mem_row),
    .rr_dep    (mem_depth),
    .rr_data   (row_rd),
    .rr_dirty  (row_dirty),
    .dirty_any (dirty_any)
  );

  always_comb begin
    state_n      = state_q;
    step_n       = step_q;
    wb_ent_n     = wb_ent_q;
    fill_ent_n   = fill_ent_q;
    fill_tile_n  = fill_tile_q;
    flushing_n   = flushing_q;
    valid_n      = valid_q;
    tag_n        = tag_q;
    rank_n       = rank_q;
    flush_pend_n = flush_pend_q;

    if (accept) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IDX_W'(e) == hit_idx)             rank_n[e] = '0;
        else if (rank_q[e] < rank_q[hit_idx]) rank_n[e] = rank_q[e] + 1'b1;
      end
    end

    if (step_adv) step_n = step_q + 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        step_n = '0;
        if (flush_pend_q) begin
          flush_pend_n = 1'b0;
          flushing_n   = 1'b1;
          wb_ent_n     = '0;
          state_n      = ST_WB;
        end else if (frag_valid && !hit) begin
          fill_ent_n      = victim;
          fill_tile_n     = frag_tile;
          valid_n[victim] = 1'b0;
          flushing_n      = 1'b0;
          wb_ent_n        = victim;
          state_n         = (valid_q[victim] && dirty_any[victim]) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        if (step_adv && step_last) begin
          if (!flushing_q)                           state_n = ST_FILL;
          else if (wb_ent_q == IDX_W'(ENTRIES - 1))  state_n = ST_DONE;
          else                                       wb_ent_n = wb_ent_q + 1'b1;
        end
      end
      ST_FILL: begin
        if (step_adv && step_last) begin
          valid_n[fill_ent_q] = 1'b1;
          tag_n[fill_ent_q]   = fill_tile_q;
          state_n             = ST_IDLE;
        end
      end
      ST_DONE: begin
        valid_n    = '0;
        flushing_n = 1'b0;
        state_n    = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase

    if (flush_req) flush_pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      wb_ent_q     <= '0;
      fill_ent_q   <= '0;
      fill_tile_q  <= '0;
      flushing_q   <= 1'b0;
      flush_pend_q <= 1'b0;
      valid_q      <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]  <= '0;
        rank_q[e] <= IDX_W'(e);
      end
    end else begin
      state_q      <= state_n;
      step_q       <= step_n;
      wb_ent_q     <= wb_ent_n;
      fill_ent_q   <= fill_ent_n;
      fill_tile_q  <= fill_tile_n;
      flushing_q   <= flushing_n;
      flush_pend_q <= flush_pend_n;
      valid_q      <= valid_n;
      tag_q        <= tag_n;
      rank_q       <= rank_n;
    end
  end
endmodule

// File: rtl/tc_tile_cache_chk.sv
module tc_tile_cache_chk #(
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frag_ready,
  input logic               flush_done,
  input logic               mem_req,
  input logic               mem_ack,
  input logic               mem_we,
  input logic               mem_depth,
  input logic [X_W+Y_W-7:0] mem_tile,
  input logic [2:0]         mem_row,
  input logic [7:0]         mem_lane_en
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_depth)
                            && $stable(mem_row) && $stable(mem_tile));

  assert_stall_on_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frag_ready |-> !mem_req);

  assert_read_full_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_lane_en == 8'hFF);

  assert_write_needs_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_lane_en != 8'h00);

  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_quiet_in_reset_R9: assert (!mem_req && !flush_done);
    end
  end
endmodule

bind tc_tile_cache tc_tile_cache_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frag_ready  (frag_ready),
  .flush_done  (flush_done),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_we      (mem_we),
  .mem_depth   (mem_depth),
  .mem_tile    (mem_tile),
  .mem_row     (mem_row),
  .mem_lane_en (mem_lane_en)
);

// File: tb/tc_tile_cache_tb.sv
`timescale 1ns/1ps
module tc_tile_cache_tb;
  localparam int XW = 6;
  localparam int YW = 6;
  localparam int TW = XW + YW - 6;
  localparam int NT = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frag_valid = 1'b0;
  logic [XW-1:0] frag_x = '0;
  logic [YW-1:0] frag_y = '0;
  logic [31:0] frag_z = '0, frag_color = '0;
  logic flush_req = 1'b0;
  logic mem_ack = 1'b0;
  logic [255:0] mem_rdata = '0;
  logic frag_ready, flush_done, mem_req, mem_we, mem_depth;
  logic [TW-1:0] mem_tile;
  logic [2:0] mem_row;
  logic [7:0] mem_lane_en;
  logic [255:0] mem_wdata;

  int checks = 0, errors = 0, n_rd = 0, n_wr = 0, log_n = 0;
  logic [255:0] colmem [NT*8];
  logic [255:0] depmem [NT*8];
  logic         lg_we   [64];
  logic [TW-1:0] lg_tile [64];
  logic [2:0]   lg_row  [64];
  logic         lg_dep  [64];
  logic [7:0]   lg_lane [64];
  logic         finished = 1'b0;

  always #4 clk = ~clk;

  tc_tile_cache #(.X_W(XW), .Y_W(YW), .ENTRIES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_x(frag_x), .frag_y(frag_y), .frag_z(frag_z), .frag_color(frag_color),
    .flush_req(flush_req), .flush_done(flush_done), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_depth(mem_depth), .mem_tile(mem_tile), .mem_row(mem_row),
    .mem_lane_en(mem_lane_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_col(int tile, int row, int lane);
    return 32'hC000_0000 | (tile << 8) | (row << 4) | lane;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pix_col(int x, int y);
    return colmem[((y >> 3) * 8 + (x >> 3)) * 8 + (y & 7)][32*(x & 7) +: 32];
  endfunction
  function automatic logic [31:0] pix_dep(int x, int y);
    return depmem[((y >> 3) * 8 + (x >> 3)) * 8 + (y & 7)][32*(x & 7) +: 32];
  endfunction

  // memory model: one wait cycle, then ack; fields must hold (R10)
  initial begin
    int wt;
    logic [TW+5:0] snap;
    wt = 0;
    snap = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (wt == 0) begin
          snap = {mem_we, mem_depth, mem_row, mem_tile};
          wt = 1;
        end else begin
          chk(snap == {mem_we, mem_depth, mem_row, mem_tile}, "R10 fields held",
              64'({mem_we, mem_depth, mem_row, mem_tile}), 64'(snap));
          wt = 0;
          if (log_n < 64) begin
            lg_we[log_n] = mem_we; lg_tile[log_n] = mem_tile; lg_row[log_n] = mem_row;
            lg_dep[log_n] = mem_depth; lg_lane[log_n] = mem_lane_en;
          end
          log_n++;
          if (mem_we) begin
            n_wr++;
            for (int l = 0; l < 8; l++) begin
              if (mem_lane_en[l]) begin
                if (mem_depth) depmem[mem_tile*8+mem_row][32*l +: 32] = mem_wdata[32*l +: 32];
                else           colmem[mem_tile*8+mem_row][32*l +: 32] = mem_wdata[32*l +: 32];
              end
            end
          end else begin
            n_rd++;
            mem_rdata = mem_depth ? depmem[mem_tile*8+mem_row] : colmem[mem_tile*8+mem_row];
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic clear_log();
    n_rd = 0; n_wr = 0; log_n = 0;
  endtask

  task automatic send_frag(input int x, input int y, input logic [31:0] z, input logic [31:0] c);
    @(negedge clk);
    frag_valid = 1'b1; frag_x = XW'(x); frag_y = YW'(y); frag_z = z; frag_color = c;
    #1;
    while (!frag_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    frag_valid = 1'b0;
  endtask

  task automatic do_flush(output int pulses);
    pulses = 0;
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (flush_done) pulses++;
      else if (pulses > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!mem_req && !flush_done, "R9 quiet in reset", 64'({mem_req, flush_done}), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && n_rd == 0 && n_wr == 0, "R9 no traffic after reset", 64'(n_rd + n_wr), 0);
    frag_x = XW'(9); frag_y = YW'(10);
    #1;
    chk(!frag_ready, "R9 entries invalid after reset", 64'(frag_ready), 0);
  endtask

  task automatic t_first_miss();
    bit ok;
    clear_log();
    send_frag(9, 10, 32'h50, 32'hAAAA_0001);
    chk(n_rd == 16 && n_wr == 0, "R2 miss loads 16 rows", 64'(n_rd), 16);
    ok = 1'b1;
    for (int k = 0; k < 16; k++)
      if (lg_we[k] || lg_row[k] != 3'(k >> 1) || lg_dep[k] != k[0]) ok = 1'b0;
    chk(ok, "R2 load order", 0, 0);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) if (lg_tile[k] != TW'(9) || lg_lane[k] != 8'hFF) ok = 1'b0;
    chk(ok, "R1 tile index 9 and full lanes", 64'(lg_tile[0]), 9);
  endtask

  task automatic t_hits();
    clear_log();
    send_frag(8, 8, 32'h10, 32'hBBBB_0002);
    send_frag(9, 10, 32'h50, 32'hDEAD_0003);
    send_frag(9, 10, 32'h60, 32'hDEAD_0004);
    send_frag(10, 10, 32'h0200_0000, 32'hDEAD_0005);
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R5 hits cause no memory traffic", 64'(log_n), 0);
  endtask

  task automatic t_flush_dirty();
    int p;
    clear_log();
    do_flush(p);
    chk(p == 1, "R8 done pulse one cycle", 64'(p), 1);
    chk(n_wr == 4 && n_rd == 0, "R4 only dirty rows written", 64'(n_wr), 4);
    chk(lg_row[0] == 0 && lg_lane[0] == 8'h01 && lg_row[2] == 2 && lg_lane[2] == 8'h02,
        "R4 lane enables follow dirty pixels", 64'({lg_row[2], lg_lane[2]}), 64'({3'd2, 8'h02}));
    chk(pix_col(9, 10) == 32'hAAAA_0001 && pix_dep(9, 10) == 32'h50,
        "R3 equal/greater depth rejected", 64'(pix_col(9, 10)), 64'h AAAA_0001);
    chk(pix_col(8, 8) == 32'hBBBB_0002 && pix_dep(8, 8) == 32'h10,
        "R3 nearer fragment stored", 64'(pix_col(8, 8)), 64'hBBBB_0002);
    chk(pix_col(10, 10) == init_col(9, 2, 2) && pix_dep(10, 10) == 32'h0100_0000,
        "R4 untouched pixel kept", 64'(pix_col(10, 10)), 64'(init_col(9, 2, 2)));
  endtask

  task automatic t_flush_clean();
    int p;
    clear_log();
    send_frag(9, 10, 32'hFFFF_FFFF, 32'h1234_5678);
    chk(n_rd == 16, "R8 flushed tile misses again", 64'(n_rd), 16);
    clear_log();
    do_flush(p);
    chk(n_wr == 0 && p == 1, "R11 clean flush writes nothing", 64'(n_wr), 0);
  endtask

  task automatic t_lru_evict();
    int p;
    clear_log();
    send_frag(1, 1, 32'h20, 32'hA0A0_0001);
    send_frag(16, 3, 32'h21, 32'hB0B0_0002);
    send_frag(1, 2, 32'h22, 32'hA0A0_0003);
    chk(n_rd == 32 && n_wr == 0, "R6 invalid entries used first", 64'(n_rd), 32);
    clear_log();
    send_frag(24, 0, 32'h23, 32'hC0C0_0004);
    chk(n_wr == 2 && n_rd == 16, "R7 victim written then loaded", 64'(n_wr), 2);
    chk(lg_we[0] && lg_we[1] && !lg_we[2] && lg_tile[0] == TW'(2) && lg_row[0] == 3,
        "R7 write-back precedes loads, LRU tile 2", 64'(lg_tile[0]), 2);
    chk(pix_col(16, 3) == 32'hB0B0_0002 && pix_dep(16, 3) == 32'h21,
        "R7 evicted pixel reached memory", 64'(pix_col(16, 3)), 64'hB0B0_0002);
    clear_log();
    send_frag(2, 2, 32'h24, 32'hA0A0_0005);
    chk(log_n == 0, "R6 most recent tile kept", 64'(log_n), 0);
    clear_log();
    do_flush(p);
    chk(n_wr == 6 && p == 1, "R8 flush writes both entries", 64'(n_wr), 6);
    chk(pix_col(2, 2) == 32'hA0A0_0005 && pix_col(24, 0) == 32'hC0C0_0004,
        "R8 flushed data in memory", 64'(pix_col(24, 0)), 64'hC0C0_0004);
  endtask

  initial begin
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 8; r++)
        for (int l = 0; l < 8; l++) begin
          colmem[t*8+r][32*l +: 32] = init_col(t, r, l);
          depmem[t*8+r][32*l +: 32] = 32'h0100_0000;
        end
    t_reset();
    t_first_miss();
    t_hits();
    t_flush_dirty();
    t_flush_clean();
    t_lru_evict();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule